// File: doc/BRIEF.md
# Bus Clock Divider Unit

This unit turns one of two fast source tick streams into three related enable streams for a bus domain. The main (A) stream is the selected source divided by a programmable ratio. A mid-speed (H) stream and a peripheral (P) stream are further divisions of the A stream. All three are single-cycle enable pulses on the fast clock and are meant to qualify logic in the domain. The outputs are not gated clocks.

All ratios and the source choice come from one 16-bit configuration word. Software updates the word with a 32-bit write: the upper half is a per-bit mask and the lower half is the data. A write that would produce the forbidden H code leaves that field unchanged and sets a sticky error flag.

A staged copy of the word drives the dividers. That copy is refreshed only at an edge where the A, H and P streams all pulse together, so no running enable period is ever cut short. The `PERI_STYLE` parameter selects a second encoding meant for a peripheral domain. In that encoding the main ratio comes from one 5-bit field and the H and P ratios are powers of two.

Top module: `busclk_divider`

## Requirements
- R1: After reset the configuration word reads 0x0000, the error flag is 0, and no enable pulses while neither source ticks.
- R2: Bit 15 of the word picks the source: 0 selects `src0_tick`, 1 selects `src1_tick`.
- R3: In the default encoding the A period, counted in selected source ticks, is (bits[7:3]+1) * (bits[2:0]+1).
- R4: In the default encoding bits[9:8] set the H period as a multiple of the A period: code 0 gives 1, code 1 gives 2, code 3 gives 4.
- R5: In the default encoding the P period is (bits[14:12]+1) A periods.
- R6: A write updates exactly those word bits whose mask bit (write bit 16+i for word bit i) is 1. Every other bit keeps its value.
- R7: In the default encoding, a write whose merged bits[9:8] would equal 2 keeps the old bits[9:8] and still updates the other masked bits. It also sets `bad_code`, which stays 1 until reset.
- R8: Every H and every P pulse coincides with an A pulse.
- R9: A newly written word takes effect only at a cycle where A, H and P pulse together. The A period in progress when the write happens keeps its old length.
- R10: With `PERI_STYLE`=1 the A period is bits[4:0]+1 ticks, the H period is 2^bits[9:8] A periods and the P period is 2^bits[13:12] A periods. H code 2 is legal in this encoding and does not set `bad_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src0_tick | input | 1 | Tick stream of the first source |
| src1_tick | input | 1 | Tick stream of the second source |
| wr_en | input | 1 | Configuration write strobe |
| wr_word | input | 32 | Mask in bits 31:16, data in bits 15:0 |
| a_en | output | 1 | Main enable pulse |
| h_en | output | 1 | Mid-speed enable pulse |
| p_en | output | 1 | Peripheral enable pulse |
| cfg_word | output | 16 | Current written configuration word |
| bad_code | output | 1 | Sticky reserved-code flag |

## Verification
The default encoding is exercised with four words, and the measured A, H and P periods are compared against the ratio formulas. These words separate the two main divider stages from each other and from the P field. They use every legal H code, and they also use the slower second source, which shows whether bit 15 truly switches the input.

Directed writes cover the remaining cases. A full-mask write carrying the reserved H code shows that the other fields still update while the H field holds. A partial-mask write shows that unmasked bits are kept. A single-bit write that only forms code 2 through merging shows that the check is applied to the merged value. A write issued in the middle of an A period shows whether that period keeps its old length.

A second instance uses the power-of-two encoding, with a word that would be illegal in the default encoding.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

    localparam int CFG_W   = 16;
    localparam int HI_W    = 5;
    localparam int LO_W    = 3;
    localparam int SUB_W   = 3;
    localparam int WR_W    = 2 * CFG_W;

    typedef struct packed {
        logic              src_pick;
        logic [HI_W-1:0]   hi_lim;
        logic [LO_W-1:0]   lo_lim;
        logic [SUB_W-1:0]  h_lim;
        logic [SUB_W-1:0]  p_lim;
    } ratio_t;

    // Turn a configuration word into terminal counts (ratio minus one).
    function automatic ratio_t decode_word(input logic [CFG_W-1:0] c, input bit peri);
        ratio_t r;
        r.src_pick = c[15];
        if (peri) begin
            r.hi_lim = c[4:0];
            r.lo_lim = '0;
            r.h_lim  = (SUB_W'(1) << c[9:8]) - SUB_W'(1);
            r.p_lim  = (SUB_W'(1) << c[13:12]) - SUB_W'(1);
        end else begin
            r.hi_lim = c[7:3];
            r.lo_lim = c[2:0];
            case (c[9:8])
                2'd0:    r.h_lim = SUB_W'(0);
                2'd3:    r.h_lim = SUB_W'(3);
                default: r.h_lim = SUB_W'(1);
            endcase
            r.p_lim  = c[14:12];
        end
        return r;
    endfunction

endpackage

// File: rtl/busclk_cfg.sv
module busclk_cfg
    import busclk_pkg::*;
#(
    parameter bit PERI_STYLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WR_W-1:0]  wr_word,
    output logic [CFG_W-1:0] cfg_q_o,
    output logic             err_q_o
);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             err;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic [CFG_W-1:0] mask_w, data_w, merged_w;

    always_comb begin
        st_d     = st_q;
        mask_w   = wr_word[WR_W-1:CFG_W];
        data_w   = wr_word[CFG_W-1:0];
        merged_w = (st_q.cfg & ~mask_w) | (data_w & mask_w);
        if (wr_en) begin
            if (!PERI_STYLE && merged_w[9:8] == 2'b10) begin
                merged_w[9:8] = st_q.cfg[9:8];
                st_d.err      = 1'b1;
            end
            st_d.cfg = merged_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_q_o = st_q.cfg;
    assign err_q_o = st_q.err;

    // R7: the reserved code never reaches the stored word
    assert_no_reserved_h_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !PERI_STYLE |-> (st_q.cfg[9:8] != 2'b10));

    // R7: the error flag is sticky
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.err) |-> st_q.err);

endmodule

// File: rtl/busclk_main_div.sv
module busclk_main_div #(
    parameter int  HI_W      = 5,
    parameter int  LO_W      = 3,
    parameter bit  TWO_STAGE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [HI_W-1:0] hi_lim,
    input  logic [LO_W-1:0] lo_lim,
    output logic            wrap
);

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } cnt_t;

    cnt_t c_d, c_q;
    logic lo_end, hi_end;

    generate
        if (TWO_STAGE) begin : g_two
            assign lo_end = (c_q.lo == lo_lim);
        end else begin : g_one
            assign lo_end = 1'b1;
        end
    endgenerate

    assign hi_end = (c_q.hi == hi_lim);
    assign wrap   = tick && lo_end && hi_end;

    always_comb begin
        c_d = c_q;
        if (tick) begin
            if (lo_end) begin
                c_d.lo = '0;
                c_d.hi = hi_end ? '0 : c_q.hi + HI_W'(1);
            end else begin
                c_d.lo = c_q.lo + LO_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // R3: stage counters stay within their terminal counts
    assert_hi_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.hi <= hi_lim);
    assert_lo_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !TWO_STAGE || (c_q.lo <= lo_lim));

endmodule

// File: rtl/busclk_sub_div.sv
module busclk_sub_div #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] lim,
    output logic         hit
);

    logic [W-1:0] cnt_d, cnt_q;

    assign hit = step && (cnt_q == lim);

    always_comb begin
        cnt_d = cnt_q;
        if (step) cnt_d = (cnt_q == lim) ? '0 : cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the count never passes its terminal value
    assert_sub_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);

endmodule

// File: rtl/busclk_divider.sv
module busclk_divider
    import busclk_pkg::*;
#(
    parameter bit PERI_STYLE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        src0_tick,
    input  logic        src1_tick,
    input  logic        wr_en,
    input  logic [31:0] wr_word,
    output logic        a_en,
    output logic        h_en,
    output logic        p_en,
    output logic [15:0] cfg_word,
    output logic        bad_code
);

    typedef struct packed {
        logic [CFG_W-1:0] act;
        logic             a;
        logic             h;
        logic             p;
    } top_state_t;

    top_state_t s_d, s_q;
    logic [CFG_W-1:0] cfg_w;
    ratio_t rat;
    logic tick_w, a_wrap, h_hit, p_hit, boundary;

    busclk_cfg #(.PERI_STYLE(PERI_STYLE)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .cfg_q_o(cfg_w), .err_q_o(bad_code)
    );

    assign rat    = decode_word(s_q.act, PERI_STYLE);
    assign tick_w = rat.src_pick ? src1_tick : src0_tick;

    busclk_main_div #(.HI_W(HI_W), .LO_W(LO_W), .TWO_STAGE(!PERI_STYLE)) main_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_w),
        .hi_lim(rat.hi_lim), .lo_lim(rat.lo_lim), .wrap(a_wrap)
    );

    busclk_sub_div #(.W(SUB_W)) hdiv_i (
        .clk(clk), .rst_n(rst_n), .step(a_wrap), .lim(rat.h_lim), .hit(h_hit)
    );

    busclk_sub_div #(.W(SUB_W)) pdiv_i (
        .clk(clk), .rst_n(rst_n), .step(a_wrap), .lim(rat.p_lim), .hit(p_hit)
    );

    assign boundary = a_wrap && h_hit && p_hit;

    always_comb begin
        s_d   = s_q;
        s_d.a = a_wrap;
        s_d.h = h_hit;
        s_d.p = p_hit;
        if (boundary) s_d.act = cfg_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign a_en     = s_q.a;
    assign h_en     = s_q.h;
    assign p_en     = s_q.p;
    assign cfg_word = cfg_w;

    // R8: H and P pulses sit on A pulses
    assert_h_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        h_en |-> a_en);
    assert_p_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        p_en |-> a_en);

    // R9: the staged word changes only together with a common pulse
    assert_update_on_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.act != $past(s_q.act)) |-> (a_en && h_en && p_en));

endmodule

// File: tb/busclk_divider_tb_top.sv
`timescale 1ns/1ps
module busclk_divider_tb_top;

    localparam real CLK_NS = 4.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src0_tick = 1'b0, src1_tick = 1'b0, run_src = 1'b0;
    logic wr_en = 1'b0, wr_en_p = 1'b0;
    logic [31:0] wr_word = '0;
    logic a_en, h_en, p_en, bad_code;
    logic a_p, h_p, p_p, bad_p;
    logic [15:0] cfg_word, cfg_p;
    logic [5:0] en_all;
    int errs = 0, checks = 0;

    always #(CLK_NS/2) clk = ~clk;

    busclk_divider dut_i (
        .clk(clk), .rst_n(rst_n), .src0_tick(src0_tick), .src1_tick(src1_tick),
        .wr_en(wr_en), .wr_word(wr_word), .a_en(a_en), .h_en(h_en), .p_en(p_en),
        .cfg_word(cfg_word), .bad_code(bad_code)
    );

    busclk_divider #(.PERI_STYLE(1'b1)) dut_p (
        .clk(clk), .rst_n(rst_n), .src0_tick(src0_tick), .src1_tick(src1_tick),
        .wr_en(wr_en_p), .wr_word(wr_word), .a_en(a_p), .h_en(h_p), .p_en(p_p),
        .cfg_word(cfg_p), .bad_code(bad_p)
    );

    assign en_all = {p_p, h_p, a_p, p_en, h_en, a_en};

    // Source 0 ticks every cycle, source 1 every second cycle
    initial begin
        forever begin
            @(negedge clk);
            src0_tick = run_src;
            src1_tick = run_src && !src1_tick;
        end
    end

    // Table: word, A period, H period, P period (in clock cycles)
    localparam int NV = 4;
    localparam logic [31:0] V_WORD [NV] = '{32'hFFFF_0000, 32'hFFFF_2111, 32'hFFFF_8308, 32'hFFFF_3003};
    localparam int V_A [NV] = '{1, 6, 4, 4};
    localparam int V_H [NV] = '{1, 12, 16, 4};
    localparam int V_P [NV] = '{1, 18, 4, 16};

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w, input bit to_peri);
        @(negedge clk);
        wr_word = w;
        if (to_peri) wr_en_p = 1'b1; else wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        wr_en_p = 1'b0;
    endtask

    task automatic measure(input int idx, output int per);
        @(negedge clk);
        while (!en_all[idx]) @(negedge clk);
        per = 0;
        do begin
            @(negedge clk);
            per++;
        end while (!en_all[idx]);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int per;
        int k;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1: reset state with no ticks
        chk("R1 cfg_word", int'(cfg_word), 0);
        chk("R1 bad_code", int'(bad_code), 0);
        chk("R1 enables idle", int'(en_all), 0);
        run_src = 1'b1;

        // R2 R3 R4 R5: table of words and expected periods
        for (int i = 0; i < NV; i++) begin
            write_cfg(V_WORD[i], 1'b0);
            repeat (600) @(negedge clk);
            measure(0, per); chk($sformatf("R2 R3 A period vec%0d", i), per, V_A[i]);
            measure(1, per); chk($sformatf("R4 H period vec%0d", i), per, V_H[i]);
            measure(2, per); chk($sformatf("R5 P period vec%0d", i), per, V_P[i]);
        end

        // R9: a write in the middle of an A period keeps its length
        write_cfg(32'hFFFF_2111, 1'b0);
        repeat (600) @(negedge clk);
        @(negedge clk);
        while (!(a_en && !h_en)) @(negedge clk);
        wr_word = 32'hFFFF_0000;
        wr_en = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (k == 1) wr_en = 1'b0;
        end while (!a_en);
        chk("R9 running period kept", k, 6);
        repeat (100) @(negedge clk);
        measure(0, per); chk("R9 new word applied", per, 1);

        // R7: reserved H code with full mask
        write_cfg(32'hFFFF_8205, 1'b0);
        @(negedge clk);
        chk("R7 other fields written", int'(cfg_word), 32'h8005);
        chk("R7 error raised", int'(bad_code), 1);

        // R6: partial mask
        write_cfg(32'h00FF_FFFF, 1'b0);
        @(negedge clk);
        chk("R6 masked merge", int'(cfg_word), 32'h80FF);
        chk("R7 error sticky", int'(bad_code), 1);
        repeat (100) @(negedge clk);
        measure(0, per); chk("R6 R2 A period after merge", per, 512);

        // R7: one mask bit forming code 2 through the merge
        write_cfg(32'h0200_0200, 1'b0);
        @(negedge clk);
        chk("R7 merged reserved code held", int'(cfg_word), 32'h80FF);

        // R10: power-of-two encoding
        write_cfg(32'hFFFF_1204, 1'b1);
        @(negedge clk);
        chk("R10 word stored", int'(cfg_p), 32'h1204);
        chk("R10 no error", int'(bad_p), 0);
        repeat (200) @(negedge clk);
        measure(3, per); chk("R10 A period", per, 5);
        measure(4, per); chk("R10 H period", per, 20);
        measure(5, per); chk("R10 P period", per, 10);

        // R8: count pulses over a window for H and P off the A pulse
        k = 0;
        repeat (200) begin
            @(negedge clk);
            if ((h_p || p_p) && !a_p) k++;
        end
        chk("R8 H/P only on A", k, 0);

        finish_run();
    end

endmodule